// File: doc/BRIEF.md
# Multi-Mode Effective Address Generator

This block forms the operand or branch-target address for one instruction per cycle. The decode stage supplies five things: a format code, the base and index register numbers with the values already read for them, an immediate field, and the address of the current instruction. The block picks up to three addends from these, adds them modulo 2^64, and cuts the sum down to the width set by the two addressing-mode bits of the status word.

The result is registered. It appears one clock after the request, together with a valid strobe and a flag that marks the one mode code that is not allowed. When that flag is set, the address is forced to zero. The block does no register-file reads, no translation, and no address-space selection.

Top module: `eff_addr_gen`

## Requirements
- R1: `out_valid` is high in the cycle after a cycle with `in_valid` high, and low after a cycle with `in_valid` low. Reset drives `out_valid`, `ea` and `mode_err` to zero. While idle, `ea` keeps its last value and `mode_err` reads zero.
- R2: Format code 0 (register) gives `base_val` as the sum. It ignores `base_num`, `index_val` and the immediate.
- R3: Format code 1 (short relative) adds `insn_addr` and `imm[15:0]`. The immediate is sign-extended and shifted left by one bit, so it counts halfwords.
- R4: Format code 2 (long relative) adds `insn_addr` and all 32 bits of `imm`. The immediate is sign-extended and shifted left by one bit.
- R5: Format code 3 (base plus displacement) adds the base term and `imm[11:0]`, zero-extended.
- R6: Format code 4 (indexed) adds the base term, the index term and `imm[11:0]`, zero-extended.
- R7: Format code 5 (long displacement) adds the base term, the index term and `imm[19:0]`, sign-extended.
- R8: In formats 3 to 5, a register number of zero makes that term zero, whatever the register value is.
- R9: All sums wrap modulo 2^64. Mode code 11 passes all 64 bits through.
- R10: Mode code 00 keeps bits 23:0 of the sum and clears the rest. Mode code 01 keeps bits 30:0 and clears the rest.
- R11: Mode code 10 gives `ea` = 0 with `mode_err` = 1. Every other mode gives `mode_err` = 0.
- R12: Format codes 6 and 7 are reserved and give a sum of zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request present this cycle |
| fmt | input | 3 | Address format code |
| mode | input | 2 | Addressing-mode bits from the status word |
| base_num | input | 4 | Base register number |
| base_val | input | 64 | Base register contents |
| index_num | input | 4 | Index register number |
| index_val | input | 64 | Index register contents |
| imm | input | 32 | Displacement or relative offset field |
| insn_addr | input | 64 | Address of the current instruction |
| out_valid | output | 1 | Result valid |
| ea | output | 64 | Effective address |
| mode_err | output | 1 | Illegal mode code was requested |

## Verification
Every result is due exactly one rising edge after its request. That edge is the only register between the inputs and `ea`, `out_valid` and `mode_err`. The bench drives each request on a falling edge and reads the matching result on the next falling edge, so sampling stays half a period away from the capturing edge. Requests are issued back to back, so each check also confirms that the result belongs to the request just before it and not to an older one. An idle cycle then checks that `out_valid` drops and that `ea` holds its last value.

// File: rtl/eag_pkg.sv
package eag_pkg;

    localparam int EA_W = 64;

    typedef enum logic [2:0] {
        FMT_REG    = 3'd0,
        FMT_REL_S  = 3'd1,
        FMT_REL_L  = 3'd2,
        FMT_BD     = 3'd3,
        FMT_BXD    = 3'd4,
        FMT_BXLD   = 3'd5
    } fmt_e;

    typedef enum logic [1:0] {
        AM_24  = 2'b00,
        AM_31  = 2'b01,
        AM_BAD = 2'b10,
        AM_64  = 2'b11
    } amode_e;

    typedef struct packed {
        logic            vld;
        logic            err;
        logic [EA_W-1:0] ea;
    } ea_state_s;

endpackage

// File: rtl/eag_term_sel.sv
module eag_term_sel
    import eag_pkg::*;
#(
    parameter int AW     = 64,
    parameter int RNW    = 4,
    parameter int IMMW   = 32,
    parameter int SDW    = 12,
    parameter int LDW    = 20,
    parameter int RELS_W = 16
) (
    input  logic [2:0]      fmt,
    input  logic [RNW-1:0]  base_num,
    input  logic [AW-1:0]   base_val,
    input  logic [RNW-1:0]  index_num,
    input  logic [AW-1:0]   index_val,
    input  logic [IMMW-1:0] imm,
    input  logic [AW-1:0]   insn_addr,
    output logic [AW-1:0]   term_a,
    output logic [AW-1:0]   term_b,
    output logic [AW-1:0]   term_c
);

    logic [AW-1:0] base_t;
    logic [AW-1:0] index_t;
    logic [AW-1:0] disp_short;
    logic [AW-1:0] disp_long;
    logic [AW-1:0] rel_s_ext;
    logic [AW-1:0] rel_l_ext;
    logic [AW-1:0] rel_s_hw;
    logic [AW-1:0] rel_l_hw;

    // register number zero means "no register"
    assign base_t  = (base_num  == '0) ? '0 : base_val;
    assign index_t = (index_num == '0) ? '0 : index_val;

    assign disp_short = {{(AW-SDW){1'b0}}, imm[SDW-1:0]};
    assign disp_long  = {{(AW-LDW){imm[LDW-1]}}, imm[LDW-1:0]};
    assign rel_s_ext  = {{(AW-RELS_W){imm[RELS_W-1]}}, imm[RELS_W-1:0]};
    assign rel_l_ext  = {{(AW-IMMW){imm[IMMW-1]}}, imm};

    // relative offsets count halfwords
    assign rel_s_hw = {rel_s_ext[AW-2:0], 1'b0};
    assign rel_l_hw = {rel_l_ext[AW-2:0], 1'b0};

    always_comb begin
        term_a = '0;
        term_b = '0;
        term_c = '0;
        case (fmt_e'(fmt))
            FMT_REG: begin
                term_a = base_val;
            end
            FMT_REL_S: begin
                term_a = insn_addr;
                term_b = rel_s_hw;
            end
            FMT_REL_L: begin
                term_a = insn_addr;
                term_b = rel_l_hw;
            end
            FMT_BD: begin
                term_a = base_t;
                term_c = disp_short;
            end
            FMT_BXD: begin
                term_a = base_t;
                term_b = index_t;
                term_c = disp_short;
            end
            FMT_BXLD: begin
                term_a = base_t;
                term_b = index_t;
                term_c = disp_long;
            end
            default: begin
                term_a = '0;
            end
        endcase
    end

endmodule

// File: rtl/eag_add3.sv
module eag_add3 #(
    parameter int AW = 64
) (
    input  logic [AW-1:0] a,
    input  logic [AW-1:0] b,
    input  logic [AW-1:0] c,
    output logic [AW-1:0] sum
);

    // carries out of the top bit are dropped: modulo 2^AW
    assign sum = a + b + c;

endmodule

// File: rtl/eag_mode_trunc.sv
module eag_mode_trunc
    import eag_pkg::*;
#(
    parameter int AW    = 64,
    parameter int W_LO  = 24,
    parameter int W_MID = 31
) (
    input  logic [AW-1:0] sum,
    input  logic [1:0]    mode,
    output logic [AW-1:0] ea,
    output logic          bad_mode
);

    localparam logic [AW-1:0] MASK_LO  = {{(AW-W_LO){1'b0}},  {W_LO{1'b1}}};
    localparam logic [AW-1:0] MASK_MID = {{(AW-W_MID){1'b0}}, {W_MID{1'b1}}};

    always_comb begin
        bad_mode = 1'b0;
        case (amode_e'(mode))
            AM_24:   ea = sum & MASK_LO;
            AM_31:   ea = sum & MASK_MID;
            AM_64:   ea = sum;
            default: begin
                ea       = '0;
                bad_mode = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/eff_addr_gen.sv
module eff_addr_gen
    import eag_pkg::*;
#(
    parameter int AW     = eag_pkg::EA_W,
    parameter int RNW    = 4,
    parameter int IMMW   = 32,
    parameter int SDW    = 12,
    parameter int LDW    = 20,
    parameter int RELS_W = 16,
    parameter int W_LO   = 24,
    parameter int W_MID  = 31
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [2:0]      fmt,
    input  logic [1:0]      mode,
    input  logic [RNW-1:0]  base_num,
    input  logic [AW-1:0]   base_val,
    input  logic [RNW-1:0]  index_num,
    input  logic [AW-1:0]   index_val,
    input  logic [IMMW-1:0] imm,
    input  logic [AW-1:0]   insn_addr,
    output logic            out_valid,
    output logic [AW-1:0]   ea,
    output logic            mode_err
);

    logic [AW-1:0] t_a;
    logic [AW-1:0] t_b;
    logic [AW-1:0] t_c;
    logic [AW-1:0] raw_sum;
    logic [AW-1:0] cut_ea;
    logic          cut_err;

    ea_state_s st_d;
    ea_state_s st_q;

    eag_term_sel #(
        .AW(AW), .RNW(RNW), .IMMW(IMMW), .SDW(SDW), .LDW(LDW), .RELS_W(RELS_W)
    ) u_terms (
        .fmt       (fmt),
        .base_num  (base_num),
        .base_val  (base_val),
        .index_num (index_num),
        .index_val (index_val),
        .imm       (imm),
        .insn_addr (insn_addr),
        .term_a    (t_a),
        .term_b    (t_b),
        .term_c    (t_c)
    );

    eag_add3 #(.AW(AW)) u_add (
        .a   (t_a),
        .b   (t_b),
        .c   (t_c),
        .sum (raw_sum)
    );

    eag_mode_trunc #(.AW(AW), .W_LO(W_LO), .W_MID(W_MID)) u_trunc (
        .sum      (raw_sum),
        .mode     (mode),
        .ea       (cut_ea),
        .bad_mode (cut_err)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        st_d.err = 1'b0;
        if (in_valid) begin
            st_d.ea  = cut_ea;
            st_d.err = cut_err;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.vld;
    assign ea        = st_q.ea;
    assign mode_err  = st_q.err;

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid) else $error("valid lost"); // R1
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && !mode_err && $stable(ea))) else $error("idle changed"); // R1
    AST_BAD_MODE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode == 2'b10) |=> (mode_err && ea == '0)) else $error("bad mode"); // R11
    AST_LEGAL_MODE_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode != 2'b10) |=> !mode_err) else $error("spurious err"); // R11
    AST_TRUNC_LO: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode == 2'b00) |=> (ea[AW-1:W_LO] == '0)) else $error("24 trunc"); // R10
    AST_TRUNC_MID: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode == 2'b01) |=> (ea[AW-1:W_MID] == '0)) else $error("31 trunc"); // R10
    AST_REG_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && fmt == 3'd0 && mode == 2'b11) |=> (ea == $past(base_val))) else $error("reg fmt"); // R2

endmodule

// File: tb/eff_addr_gen_tb.sv
module eff_addr_gen_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [2:0]  fmt = '0;
    logic [1:0]  mode = '0;
    logic [3:0]  base_num = '0;
    logic [63:0] base_val = '0;
    logic [3:0]  index_num = '0;
    logic [63:0] index_val = '0;
    logic [31:0] imm = '0;
    logic [63:0] insn_addr = '0;
    logic        out_valid;
    logic [63:0] ea;
    logic        mode_err;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    eff_addr_gen u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .fmt(fmt), .mode(mode),
        .base_num(base_num), .base_val(base_val), .index_num(index_num),
        .index_val(index_val), .imm(imm), .insn_addr(insn_addr),
        .out_valid(out_valid), .ea(ea), .mode_err(mode_err)
    );

    function automatic logic [63:0] model(input logic [2:0] f, input logic [1:0] m,
                                          input logic [3:0] bn, input logic [63:0] bv,
                                          input logic [3:0] xn, input logic [63:0] xv,
                                          input logic [31:0] im, input logic [63:0] ia);
        logic [63:0] b;
        logic [63:0] x;
        logic [63:0] s;
        b = (bn == 4'd0) ? 64'd0 : bv;
        x = (xn == 4'd0) ? 64'd0 : xv;
        case (f)
            3'd0:    s = bv;
            3'd1:    s = ia + 64'($signed(im[15:0])) * 64'd2;
            3'd2:    s = ia + 64'($signed(im)) * 64'd2;
            3'd3:    s = b + 64'(im[11:0]);
            3'd4:    s = b + x + 64'(im[11:0]);
            3'd5:    s = b + x + 64'($signed(im[19:0]));
            default: s = 64'd0;
        endcase
        case (m)
            2'b00:   return s % (64'd1 << 24);
            2'b01:   return s % (64'd1 << 31);
            2'b11:   return s;
            default: return 64'd0;
        endcase
    endfunction

    function automatic string tag_of(input logic [2:0] f, input logic [1:0] m, input int p);
        if (m == 2'b10) return "R11";
        if (m != 2'b11 && p == 4) return "R10";
        if (p == 1 && m == 2'b11) return "R9";
        if (f >= 3'd3 && f <= 3'd5 && (p == 2 || p == 3)) return "R8";
        case (f)
            3'd0: return "R2";
            3'd1: return "R3";
            3'd2: return "R4";
            3'd3: return "R5";
            3'd4: return "R6";
            3'd5: return "R7";
            default: return "R12";
        endcase
    endfunction

    task automatic check64(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic set_pattern(input int p);
        case (p)
            0: begin base_num = 4'd3; base_val = 64'h0000_0000_0012_3400;
                     index_num = 4'd5; index_val = 64'h0000_0000_0000_0100;
                     imm = 32'h0000_0ABC; insn_addr = 64'h0000_0000_0040_0000; end
            1: begin base_num = 4'd7; base_val = 64'hFFFF_FFFF_FFFF_FF00;
                     index_num = 4'd9; index_val = 64'h0000_0000_0000_0080;
                     imm = 32'hFFFF_8FFF; insn_addr = 64'hFFFF_FFFF_FFFF_FFF0; end
            2: begin base_num = 4'd0; base_val = 64'h1111_2222_3333_4444;
                     index_num = 4'd2; index_val = 64'h0000_0000_8000_0000;
                     imm = 32'h000F_F001; insn_addr = 64'h0000_0001_0000_0000; end
            3: begin base_num = 4'd15; base_val = 64'h0000_0000_7FFF_FFFE;
                     index_num = 4'd0; index_val = 64'h5555_5555_5555_5555;
                     imm = 32'h8000_0001; insn_addr = 64'h0000_0000_0000_1000; end
            default: begin base_num = 4'd1; base_val = 64'hABCD_EF01_FFFF_FFF0;
                     index_num = 4'd4; index_val = 64'h0123_4567_0100_0020;
                     imm = 32'h7FFF_7FFF; insn_addr = 64'h8765_4321_FFFF_FF00; end
        endcase
    endtask

    initial begin
        #(200_000 * 10);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check64("R1", {63'd0, out_valid}, 64'd0);
        check64("R1", ea, 64'd0);
        check64("R1", {63'd0, mode_err}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int p = 0; p < 5; p++) begin
            for (int f = 0; f < 8; f++) begin
                for (int m = 0; m < 4; m++) begin
                    logic [63:0] exp_ea;
                    string tg;
                    fmt = 3'(f);
                    mode = 2'(m);
                    set_pattern(p);
                    in_valid = 1'b1;
                    exp_ea = model(fmt, mode, base_num, base_val, index_num, index_val, imm, insn_addr);
                    tg = tag_of(fmt, mode, p);
                    @(negedge clk);
                    check64("R1", {63'd0, out_valid}, 64'd1);
                    check64(tg, ea, exp_ea);
                    check64("R11", {63'd0, mode_err}, {63'd0, (m == 2)});
                end
            end
        end

        // R1: idle cycle keeps address, drops valid and error
        begin
            logic [63:0] last;
            fmt = 3'd0; mode = 2'b11; base_val = 64'hDEAD_BEEF_0000_1234; in_valid = 1'b1;
            @(negedge clk);
            last = ea;
            check64("R2", last, 64'hDEAD_BEEF_0000_1234);
            in_valid = 1'b0; base_val = 64'h0; mode = 2'b10;
            @(negedge clk);
            check64("R1", {63'd0, out_valid}, 64'd0);
            check64("R1", ea, last);
            check64("R1", {63'd0, mode_err}, 64'd0);
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule